// File: doc/BRIEF.md
# Sign-Corrected Gain Control Loop for a Decision Feedback Receiver

This block is a digital automatic gain control loop. It sits in front of a decision feedback equalizer. On every clock it takes four inputs: the forward equalizer output, the precomputed sum of the feedback taps, and the present and previous bit decisions. It adds the two equalizer outputs to form the slicer input. At a data transition it measures how far that value lies from its ideal level. On all other samples the loop does nothing.

The direction of each correction comes from the sign of the forward equalizer output, not from the bit decision. When decision feedback pushes the slicer input across zero, the two signs disagree. Taking the sign from the decision would then drive the gain the wrong way.

The corrections are integrated in a first-order loop filter that holds the gain in the log2 domain. The filter state is turned into a linear gain word by two parts:

- a shift taken from the integer part of the state;
- a 16-entry mantissa from the fractional part.

The gain word scales the raw incoming samples. Because the gain is exponential in the state, each correction step changes the gain by a fixed ratio, whatever the present gain is. A freeze input holds the loop over fields that carry no data.

Top module: `dfe_agc_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the state goes to log2 gain 0. After that edge `gain_word` reads 8192 (1.0) and `samp_out` reads 0.
- R2: Equalizer samples and decisions are coded as follows.
  - `feq_in` and `fb_in` are signed 12-bit values. Their sum is the slicer input.
  - A decision of 1 means +1 and selects the target +512. A decision of 0 selects -512.
  - The loop input is the target minus the slicer input. It is negated when `feq_in` is negative. A `feq_in` of zero counts as positive.
- R3: When `dec_now` equals `dec_prev`, the state and `gain_word` keep their values on the next clock.
- R4: While `freeze` is high, the state and `gain_word` keep their values, even at data transitions.
- R5: The loop input is arithmetically shifted right by `loop_shift` (0 to 7 bits, rounding toward minus infinity). It is then added to the state. The state holds log2 of the gain with 12 fractional bits.
- R6: When the forward equalizer output and the decision have opposite signs, the update follows the sign of `feq_in`. For example, with decision +1, a slicer input below +512 and a negative `feq_in`, the gain must not rise.
- R7: `gain_word` is unsigned with 13 fractional bits. It equals round(1024·2^(k/16)) shifted left by (i+3). Here i is the integer part of the state (rounded toward minus infinity) and k is bits 11..8 of the state.
- R8: The state is clamped to the range [-3, 3) in log2. `gain_word` therefore stays between 1024 (0.125) and 62752 (about 7.66).
- R9: `samp_out` equals `samp_in` × `gain_word` / 8192, rounded toward minus infinity and saturated to [-2048, 2047]. It is registered, so it appears one clock after the input, using the gain word of the input's cycle.
- R10: In closed loop with a channel gain of 0.2, the gain settles near 5. After a step of the channel gain to 0.4, it settles again near 2.5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Hold the loop state |
| loop_shift | input | 3 | Loop gain as a right shift, 0 to 7 |
| samp_in | input | 12 | Raw signed sample to be scaled |
| feq_in | input | 12 | Signed forward equalizer output |
| fb_in | input | 12 | Signed sum of the feedback taps |
| dec_now | input | 1 | Current bit decision (1 means +1) |
| dec_prev | input | 1 | Previous bit decision |
| samp_out | output | 12 | Scaled, saturated sample, one clock late |
| gain_word | output | 16 | Current linear gain, 13 fractional bits |

## Verification
The bench sweeps every loop shift over a grid of forward and feedback values and all four decision pairs. That grid includes cases where the forward output opposes the decision. A design that steered by the decision would move the gain the wrong way on exactly those samples.

A slow staircase walks the state through every mantissa entry and across an octave boundary. This catches a wrong table entry, or a shift that is off by one where the integer part carries.

Long runs of one-sided error drive the state into both clamps. A state that wrapped instead of saturating would jump from maximum to minimum gain. A closed-loop run at channel gains of 0.2 and then 0.4 confirms that the loop settles at the right point and does not wander off.

// File: rtl/dfe_agc_pkg.sv
package dfe_agc_pkg;
   // mantissa precision of the exponential table (fixed by the table below)
   localparam int MANT_FB    = 10;
   localparam int MANT_IDX_W = 4;
   typedef logic [MANT_FB:0] mant_t;

   // round(1024 * 2^(k/16)) for one octave
   function automatic mant_t mant_of(input logic [MANT_IDX_W-1:0] k);
      case (k)
         4'd0:    return 11'd1024;
         4'd1:    return 11'd1069;
         4'd2:    return 11'd1117;
         4'd3:    return 11'd1166;
         4'd4:    return 11'd1218;
         4'd5:    return 11'd1272;
         4'd6:    return 11'd1328;
         4'd7:    return 11'd1387;
         4'd8:    return 11'd1448;
         4'd9:    return 11'd1512;
         4'd10:   return 11'd1579;
         4'd11:   return 11'd1649;
         4'd12:   return 11'd1722;
         4'd13:   return 11'd1798;
         4'd14:   return 11'd1878;
         default: return 11'd1961;
      endcase
   endfunction
endpackage

// File: rtl/agc_err_gen.sv
module agc_err_gen #(
   parameter  int DW  = 12,
   parameter  int REF = 512,
   localparam int UW  = DW + 3
) (
   input  logic [DW-1:0] feq,
   input  logic [DW-1:0] fb,
   input  logic          dec_now,
   input  logic          dec_prev,
   output logic          upd,
   output logic [UW-1:0] loop_in
);
   localparam logic [DW+1:0] REF_V = (DW+2)'(REF);

   logic [DW:0]   slc;
   logic [DW+1:0] tgt;
   logic [DW+1:0] amp_err;

   always_comb begin
      slc     = {feq[DW-1], feq} + {fb[DW-1], fb};
      tgt     = dec_now ? REF_V : -REF_V;
      amp_err = tgt - {slc[DW], slc};
      // direction from the forward equalizer sign, not from the decision
      loop_in = feq[DW-1] ? -{amp_err[DW+1], amp_err} : {amp_err[DW+1], amp_err};
      upd     = dec_now ^ dec_prev;
   end
endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter #(
   parameter int UW      = 15,
   parameter int AW      = 15,
   parameter int SHW     = 3,
   parameter int ACC_MIN = -12288,
   parameter int ACC_MAX = 12287
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   input  logic [SHW-1:0] shamt,
   input  logic [UW-1:0]  loop_in,
   output logic [AW-1:0]  acc
);
   localparam int SW = ((AW > UW) ? AW : UW) + 1;
   localparam logic signed [SW-1:0] LIM_HI = SW'(ACC_MAX);
   localparam logic signed [SW-1:0] LIM_LO = SW'(ACC_MIN);

   logic [AW-1:0]          acc_q;
   logic [AW-1:0]          acc_nx;
   logic signed [UW-1:0]   scaled;
   logic signed [SW-1:0]   sum;

   always_comb begin
      scaled = $signed(loop_in) >>> shamt;
      sum    = $signed({{(SW-AW){acc_q[AW-1]}}, acc_q})
             + $signed({{(SW-UW){scaled[UW-1]}}, scaled});
      if (sum > LIM_HI)      acc_nx = LIM_HI[AW-1:0];
      else if (sum < LIM_LO) acc_nx = LIM_LO[AW-1:0];
      else                   acc_nx = sum[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= acc_nx;
   end

   assign acc = acc_q;
endmodule

// File: rtl/agc_exp_gain.sv
module agc_exp_gain import dfe_agc_pkg::*; #(
   parameter int AW  = 15,
   parameter int LFB = 12,
   parameter int LO  = 3,
   parameter int HI  = 3,
   parameter int GW  = 16
) (
   input  logic [AW-1:0] acc,
   output logic [GW-1:0] gain
);
   localparam int SAW = $clog2(LO + HI);

   logic signed [AW-1:0]   ipart;
   logic [SAW-1:0]         sa;
   logic [MANT_IDX_W-1:0]  idx;

   always_comb begin
      ipart = $signed(acc) >>> LFB;
      sa    = SAW'(ipart + AW'(LO));
      idx   = MANT_IDX_W'(acc >> (LFB - MANT_IDX_W));
      gain  = {{(GW-MANT_FB-1){1'b0}}, mant_of(idx)} << sa;
   end
endmodule

// File: rtl/dfe_agc_loop.sv
module dfe_agc_loop import dfe_agc_pkg::*; #(
   parameter  int DW     = 12,
   parameter  int REF    = 512,
   parameter  int LFB    = 12,
   parameter  int LOG_LO = 3,
   parameter  int LOG_HI = 3,
   parameter  int SHW    = 3,
   localparam int GW     = MANT_FB + LOG_LO + LOG_HI
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           freeze,
   input  logic [SHW-1:0] loop_shift,
   input  logic [DW-1:0]  samp_in,
   input  logic [DW-1:0]  feq_in,
   input  logic [DW-1:0]  fb_in,
   input  logic           dec_now,
   input  logic           dec_prev,
   output logic [DW-1:0]  samp_out,
   output logic [GW-1:0]  gain_word
);
   localparam int UW      = DW + 3;
   localparam int MX      = (LOG_LO > LOG_HI) ? LOG_LO : LOG_HI;
   localparam int AW      = LFB + $clog2(MX) + 1;
   localparam int ACC_MIN = -(LOG_LO << LFB);
   localparam int ACC_MAX = (LOG_HI << LFB) - 1;
   localparam int GFB     = MANT_FB + LOG_LO;
   localparam int PW      = DW + GW + 1;

   if (LFB < MANT_IDX_W) begin : g_bad_lfb
      $error("LFB must cover the mantissa index");
   end
   if (LOG_LO < 1 || LOG_HI < 1) begin : g_bad_range
      $error("log gain range must span both sides of unity");
   end
   if (REF >= (1 << (DW - 1))) begin : g_bad_ref
      $error("REF must fit the sample width");
   end

   logic          upd;
   logic [UW-1:0] loop_in;
   logic [AW-1:0] acc;

   agc_err_gen #(.DW(DW), .REF(REF)) u_err (
      .feq(feq_in), .fb(fb_in), .dec_now(dec_now), .dec_prev(dec_prev),
      .upd(upd), .loop_in(loop_in)
   );

   agc_loop_filter #(.UW(UW), .AW(AW), .SHW(SHW),
                     .ACC_MIN(ACC_MIN), .ACC_MAX(ACC_MAX)) u_filt (
      .clk(clk), .rst(rst), .en(upd & ~freeze), .shamt(loop_shift),
      .loop_in(loop_in), .acc(acc)
   );

   agc_exp_gain #(.AW(AW), .LFB(LFB), .LO(LOG_LO), .HI(LOG_HI), .GW(GW)) u_exp (
      .acc(acc), .gain(gain_word)
   );

   // sample scaling and saturation
   logic [PW-1:0]        prod;
   logic signed [PW-1:0] shifted;
   logic [DW-1:0]        sat_val;

   always_comb begin
      prod    = {{(PW-DW){samp_in[DW-1]}}, samp_in} * {{(PW-GW){1'b0}}, gain_word};
      shifted = $signed(prod) >>> GFB;
      if (shifted[PW-1:DW-1] != '0 && shifted[PW-1:DW-1] != '1)
         sat_val = shifted[PW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else
         sat_val = shifted[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) samp_out <= '0;
      else     samp_out <= sat_val;
   end
endmodule

module agc_loop_chk import dfe_agc_pkg::*; #(
   parameter int DW  = 12,
   parameter int REF = 512,
   parameter int GW  = 16,
   parameter int LO  = 3,
   parameter int HI  = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          freeze,
   input logic [DW-1:0] samp_in,
   input logic [DW-1:0] feq_in,
   input logic [DW-1:0] fb_in,
   input logic          dec_now,
   input logic          dec_prev,
   input logic [DW-1:0] samp_out,
   input logic [GW-1:0] gain_word
);
   localparam logic [GW-1:0]        UNITY = GW'(1) << (MANT_FB + LO);
   localparam logic [GW-1:0]        GMIN  = GW'(mant_of(4'd0));
   localparam logic [GW-1:0]        GMAX  = GW'(mant_of(4'd15)) << (LO + HI - 1);
   localparam logic signed [DW:0]   REF_S = (DW+1)'(REF);

   logic signed [DW:0] s_chk;
   assign s_chk = {feq_in[DW-1], feq_in} + {fb_in[DW-1], fb_in};

   a_r1_reset_unity: assert property (@(posedge clk)
      rst |=> (gain_word == UNITY && samp_out == '0));

   a_r3_hold_no_transition: assert property (@(posedge clk) disable iff (rst)
      (dec_now == dec_prev) |=> $stable(gain_word));

   a_r4_freeze_hold: assert property (@(posedge clk) disable iff (rst)
      freeze |=> $stable(gain_word));

   a_r6_pos_direction: assert property (@(posedge clk) disable iff (rst)
      (dec_now && !dec_prev && !freeze && !feq_in[DW-1] && s_chk < REF_S)
      |=> gain_word >= $past(gain_word));

   a_r6_neg_direction: assert property (@(posedge clk) disable iff (rst)
      (dec_now && !dec_prev && !freeze && feq_in[DW-1] && s_chk < REF_S)
      |=> gain_word <= $past(gain_word));

   a_r8_gain_bounds: assert property (@(posedge clk) disable iff (rst)
      gain_word >= GMIN && gain_word <= GMAX);

   a_r9_unity_pass: assert property (@(posedge clk) disable iff (rst)
      (gain_word == UNITY) |=> samp_out == $past(samp_in));
endmodule

bind dfe_agc_loop agc_loop_chk #(
   .DW(DW), .REF(REF), .GW(GW), .LO(LOG_LO), .HI(LOG_HI)
) u_chk (
   .clk(clk), .rst(rst), .freeze(freeze), .samp_in(samp_in),
   .feq_in(feq_in), .fb_in(fb_in), .dec_now(dec_now), .dec_prev(dec_prev),
   .samp_out(samp_out), .gain_word(gain_word)
);

// File: tb/sim_dfe_agc_loop.sv
module sim_dfe_agc_loop;
   localparam int CLK_PERIOD = 10;
   localparam int REF = 512;
   localparam int LFB = 12;
   localparam int LO  = 3;
   localparam int GFB = 13;
   localparam int AMIN = -12288;
   localparam int AMAX = 12287;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic freeze = 1'b0;
   logic [2:0] loop_shift = '0;
   logic signed [11:0] samp_in = '0;
   logic signed [11:0] feq_in = '0;
   logic signed [11:0] fb_in = '0;
   logic dec_now = 1'b0;
   logic dec_prev = 1'b0;
   logic signed [11:0] samp_out;
   logic [15:0] gain_word;

   int n_chk = 0;
   int n_fail = 0;
   int m_acc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dfe_agc_loop u0 (
      .clk(clk), .rst(rst), .freeze(freeze), .loop_shift(loop_shift),
      .samp_in(samp_in), .feq_in(feq_in), .fb_in(fb_in),
      .dec_now(dec_now), .dec_prev(dec_prev),
      .samp_out(samp_out), .gain_word(gain_word)
   );

   function automatic int mant_ref(int k);
      return $rtoi(1024.0 * (2.0 ** (real'(k) / 16.0)) + 0.5);
   endfunction

   function automatic int gain_ref(int acc);
      int ip;
      int k;
      ip = acc >>> LFB;
      k  = (acc >>> (LFB - 4)) & 15;
      return mant_ref(k) << (ip + LO);
   endfunction

   function automatic int sat12(int v);
      if (v > 2047)  return 2047;
      if (v < -2048) return -2048;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      m_acc = 0;
      check(int'(gain_word) == 8192, "R1 gain", int'(gain_word), 8192);
      check(int'(samp_out) == 0, "R1 samp", int'(samp_out), 0);
      rst = 1'b0;
   endtask

   // drive one cycle, update model, check after the edge
   task automatic step(input int s, input int f, input int b, input bit d, input bit dp,
                       input bit fr, input int sh, input string req);
      int g_now;
      int exp_out;
      int sl;
      int t;
      int e;
      int u;
      int g_exp;
      g_now   = gain_ref(m_acc);
      exp_out = sat12((s * g_now) >>> GFB);
      samp_in = 12'(s); feq_in = 12'(f); fb_in = 12'(b);
      dec_now = d; dec_prev = dp; freeze = fr; loop_shift = 3'(sh);
      if (d != dp && !fr) begin
         sl = f + b;
         t  = d ? REF : -REF;
         e  = t - sl;
         u  = (f < 0) ? -e : e;
         m_acc = m_acc + (u >>> sh);
         if (m_acc > AMAX) m_acc = AMAX;
         if (m_acc < AMIN) m_acc = AMIN;
      end
      @(posedge clk);
      #1;
      g_exp = gain_ref(m_acc);
      check(int'(gain_word) == g_exp, req, int'(gain_word), g_exp);
      check(int'(samp_out) == exp_out, "R9", int'(samp_out), exp_out);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int fv[7];
      int bv[3];
      real gr;
      fv = '{-700, -300, -1, 0, 1, 250, 600};
      bv = '{-400, 0, 350};
      #1;
      do_reset();

      // R9: unity gain pass-through over the sample range, no transitions (R3)
      for (int v = -2048; v < 2048; v += 37)
         step(v, 0, 0, 1'b0, 1'b0, 1'b0, 0, "R3");

      // R2/R5/R6/R3 sweep over shifts, values and decision pairs
      for (int sh = 0; sh < 8; sh++)
         for (int i = 0; i < 7; i++)
            for (int j = 0; j < 3; j++)
               for (int dp = 0; dp < 4; dp++) begin
                  bit d  = dp[1];
                  bit p  = dp[0];
                  bit op = (fv[i] < 0) == d;
                  string rq;
                  if (d == p)  rq = "R3";
                  else if (op) rq = "R6 R5";
                  else         rq = "R2 R5";
                  step(sat12(fv[i] * 3), fv[i], bv[j], d, p, 1'b0, sh, rq);
               end

      // R4: freeze holds at transitions
      for (int n = 0; n < 8; n++)
         step(100, 300 - n * 90, -200, n[0], ~n[0], 1'b1, 0, "R4");

      // R8: drive into upper clamp then lower clamp
      for (int n = 0; n < 12; n++)
         step(2000, 1, -2000, 1'b1, 1'b0, 1'b0, 0, "R8");
      check(int'(gain_word) == 62752, "R8 max", int'(gain_word), 62752);
      for (int n = 0; n < 20; n++)
         step(-2000, -1, -2000, 1'b1, 1'b0, 1'b0, 0, "R8");
      check(int'(gain_word) == 1024, "R8 min", int'(gain_word), 1024);

      // R7: staircase of one mantissa step per update across an octave boundary
      do_reset();
      for (int n = 0; n < 32; n++) begin
         if (n[0]) step(50, 0, -768, 1'b0, 1'b1, 1'b0, 0, "R7");
         else      step(50, 256, 0, 1'b1, 1'b0, 1'b0, 0, "R7");
         if (n == 15)
            check(int'(gain_word) == 16384, "R7 octave", int'(gain_word), 16384);
      end

      // R10: closed loop with channel gain 0.2 then 0.4
      do_reset();
      loop_shift = 3'd3;
      samp_in = '0; fb_in = '0; freeze = 1'b0;
      for (int ph = 0; ph < 2; ph++) begin
         real chan;
         real tgt;
         chan = (ph == 0) ? 0.2 : 0.4;
         tgt  = 1.0 / chan;
         for (int n = 0; n < 2500; n++) begin
            int amp;
            bit d;
            d   = n[0];
            amp = $rtoi(chan * real'(gain_word) / 8192.0 * real'(REF) + 0.5);
            feq_in   = d ? 12'(amp) : 12'(-amp);
            dec_now  = d;
            dec_prev = ~d;
            @(posedge clk);
            #1;
         end
         gr = real'(gain_word) / 8192.0;
         check(gr > tgt * 0.93 && gr < tgt * 1.07, "R10",
               $rtoi(gr * 1000.0), $rtoi(tgt * 1000.0));
      end

      summary();
      $finish;
   end
endmodule